// File: doc/BRIEF.md
# OSD Pixel Colour Mixer with Blink

This block sits at the very end of an on-screen-display pipeline. For every output dot it takes the decoded glyph bit, the cell's attribute (foreground colour, background colour, blink flag), an indication that the dot is part of a character outline, and the hit and colour results of the window logic. It turns these into one 3-bit RGB value and a fast-blank signal that the video mixer uses to cut the picture. The font lookup, window geometry and sync timing are computed upstream and arrive as plain inputs.

The block also holds the blink time base. A counter advances on each leading edge of the vertical sync input, after the input has been synchronised and its polarity corrected. The top bit of the counter hides blinking glyphs for half of every 64-frame period. When the display is switched off, the outputs fall to zero. A separate output-enable then tells the pad either to drive those zeros or to release the lines.

Each colour is a 3-bit code {R,G,B}: 000 black, 001 blue, 010 green, 011 cyan, 100 red, 101 magenta, 110 yellow, 111 white. The outputs are registered: a dot presented at one rising clock edge appears on `rgb`/`blank`/`out_en` right after that edge.

Top module: `osd_pixel_mixer`

## Requirements
- R1: With the display on and a visible glyph dot (`fg_bit`=1, not blinked off), `rgb` equals `cell_fg` and `blank` is 1, whatever the other sources are and whatever `blank_fg_only` is.
- R2: With no visible glyph dot, an outline dot (`edge_dot`=1) with `edge_en`=1 shows `edge_color` with `blank` 1. With `edge_en`=0 the outline dot has no effect and the lower sources decide.
- R3: With neither a glyph nor an enabled outline dot, a non-zero `cell_bg` is shown, taking priority over both window sources.
- R4: A `cell_bg` of 000 is transparent. The window shadow colour `wshd_color` is shown if `wshd_hit`=1. Otherwise `win_color` is shown if `win_hit`=1.
- R5: When no source applies, `rgb` is 000 and `blank` is 0.
- R6: With `blank_fg_only`=0, `blank` is 1 for every painted dot (R1 to R4). With `blank_fg_only`=1, `blank` is 1 only for glyph and outline dots, while background and window dots keep their colour with `blank` 0.
- R7: A cell with `cell_blink`=1 has its glyph dots hidden, and its background path shown, while bit 5 of the count of active VS edges is 1. The glyph is visible for counts 0 to 31 and hidden for counts 32 to 63, and the count wraps modulo 64.
- R8: With `vs_pos_pol`=1, rising edges of `vs_in` are counted. With `vs_pos_pol`=0, falling edges are counted and rising edges are not.
- R9: A high `soft_rst` clears the VS edge count, so blinking glyphs become visible.
- R10: With `osd_en`=0, `rgb` and `blank` are 0 and `out_en` equals `drive_low_sel` (1 = drive low, 0 = release). With `osd_en`=1, `out_en` is 1.
- R11: After reset, `rgb`, `blank` and `out_en` are 0. Outputs reflect the inputs sampled at the preceding rising edge, one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear of the blink time base |
| osd_en | input | 1 | Display enable |
| drive_low_sel | input | 1 | When disabled: 1 drive outputs low, 0 release them |
| blank_fg_only | input | 1 | 1: blank only for glyph and outline dots |
| vs_in | input | 1 | Vertical sync, asynchronous |
| vs_pos_pol | input | 1 | 1: VS active high, 0: active low |
| fg_bit | input | 1 | Glyph dot from font lookup |
| cell_blink | input | 1 | Cell blink flag |
| cell_fg | input | 3 | Cell foreground colour |
| cell_bg | input | 3 | Cell background colour, 000 transparent |
| edge_dot | input | 1 | Dot belongs to a glyph border or shadow |
| edge_en | input | 1 | Border/shadow rendering enable |
| edge_color | input | 3 | Common border/shadow colour |
| win_hit | input | 1 | Dot lies in the winning enabled window |
| win_color | input | 3 | Colour of that window |
| wshd_hit | input | 1 | Dot lies in a window's shadow band |
| wshd_color | input | 3 | Colour of that shadow |
| rgb | output | 3 | Registered colour {R,G,B} |
| blank | output | 1 | Registered fast-blank |
| out_en | output | 1 | Pad drive enable for rgb and blank |

## Verification
The priority chain is tested by stacking sources on one dot and removing them one at a time: glyph over outline, outline over an opaque background, background over window shadow, shadow over window, and finally nothing. A wrong order shows up as a colour from the neighbouring level. Each stack is repeated with `blank_fg_only` set, which separates the colour choice from the blank policy. The blink path is driven with counted VS pulses through the 31/32 and 63/64 boundaries in both polarities and across a soft reset. Disabled-display vectors carry an active glyph, so that any leak through the enable gating is visible.

// File: rtl/osd_mix_pkg.sv
package osd_mix_pkg;

  localparam int CW = 3;

  typedef logic [CW-1:0] color_t;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_FG     = 3'd1,
    SRC_BORDER = 3'd2,
    SRC_BG     = 3'd3,
    SRC_WSHD   = 3'd4,
    SRC_WIN    = 3'd5
  } src_e;

  // Background code zero means no background at all.
  function automatic logic bg_opaque(color_t c);
    return c != '0;
  endfunction

  // Which sources assert the fast-blank signal under the chosen policy.
  function automatic logic blank_for(src_e s, logic fg_only);
    case (s)
      SRC_FG, SRC_BORDER: return 1'b1;
      SRC_NONE:           return 1'b0;
      default:            return ~fg_only;
    endcase
  endfunction

endpackage

// File: rtl/osd_vs_blink.sv
module osd_vs_blink #(
  parameter int DIV_LOG2    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic vs_in,
  input  logic vs_pos_pol,
  output logic vs_edge,
  output logic blink_on
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw, raw_q;
  logic [DIV_LOG2-1:0]    cnt_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= vs_in;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], vs_in};
    end
  endgenerate

  assign raw = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw;

  // Leading edge of the polarity-corrected sync pulse.
  assign vs_edge = vs_pos_pol ? (raw & ~raw_q) : (~raw & raw_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt_q <= '0;
    else if (soft_rst) cnt_q <= '0;
    else if (vs_edge)  cnt_q <= cnt_q + 1'b1;

  // Visible during the lower half of the period: 50 % duty.
  assign blink_on = ~cnt_q[DIV_LOG2-1];

endmodule

// File: rtl/osd_color_sel.sv
module osd_color_sel
  import osd_mix_pkg::*;
(
  input  logic   fg_bit,
  input  logic   cell_blink,
  input  logic   blink_on,
  input  color_t cell_fg,
  input  color_t cell_bg,
  input  logic   edge_dot,
  input  logic   edge_en,
  input  color_t edge_color,
  input  logic   win_hit,
  input  color_t win_color,
  input  logic   wshd_hit,
  input  color_t wshd_color,
  output src_e   src,
  output color_t color
);

  logic fg_vis;
  assign fg_vis = fg_bit & (~cell_blink | blink_on);

  always_comb begin
    src   = SRC_NONE;
    color = '0;
    if (fg_vis) begin
      src   = SRC_FG;
      color = cell_fg;
    end else if (edge_dot && edge_en) begin
      src   = SRC_BORDER;
      color = edge_color;
    end else if (bg_opaque(cell_bg)) begin
      src   = SRC_BG;
      color = cell_bg;
    end else if (wshd_hit) begin
      src   = SRC_WSHD;
      color = wshd_color;
    end else if (win_hit) begin
      src   = SRC_WIN;
      color = win_color;
    end
  end

endmodule

// File: rtl/osd_out_stage.sv
module osd_out_stage
  import osd_mix_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   osd_en,
  input  logic   drive_low_sel,
  input  logic   blank_fg_only,
  input  src_e   src,
  input  color_t color,
  output color_t rgb,
  output logic   blank,
  output logic   out_en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb    <= '0;
      blank  <= 1'b0;
      out_en <= 1'b0;
    end else if (osd_en) begin
      rgb    <= color;
      blank  <= blank_for(src, blank_fg_only);
      out_en <= 1'b1;
    end else begin
      rgb    <= '0;
      blank  <= 1'b0;
      out_en <= drive_low_sel;
    end
  end

endmodule

// File: rtl/osd_pixel_mixer.sv
module osd_pixel_mixer
  import osd_mix_pkg::*;
#(
  parameter int BLINK_DIV_LOG2 = 6,
  parameter int VS_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       osd_en,
  input  logic       drive_low_sel,
  input  logic       blank_fg_only,
  input  logic       vs_in,
  input  logic       vs_pos_pol,
  input  logic       fg_bit,
  input  logic       cell_blink,
  input  logic [2:0] cell_fg,
  input  logic [2:0] cell_bg,
  input  logic       edge_dot,
  input  logic       edge_en,
  input  logic [2:0] edge_color,
  input  logic       win_hit,
  input  logic [2:0] win_color,
  input  logic       wshd_hit,
  input  logic [2:0] wshd_color,
  output logic [2:0] rgb,
  output logic       blank,
  output logic       out_en
);

  // Named internal events, observed by the bound checker.
  logic   vs_edge;
  logic   blink_on;
  src_e   sel_src;
  color_t sel_color;

  osd_vs_blink #(
    .DIV_LOG2    (BLINK_DIV_LOG2),
    .SYNC_STAGES (VS_SYNC_STAGES)
  ) u_blink (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .vs_in      (vs_in),
    .vs_pos_pol (vs_pos_pol),
    .vs_edge    (vs_edge),
    .blink_on   (blink_on)
  );

  osd_color_sel u_sel (
    .fg_bit     (fg_bit),
    .cell_blink (cell_blink),
    .blink_on   (blink_on),
    .cell_fg    (cell_fg),
    .cell_bg    (cell_bg),
    .edge_dot   (edge_dot),
    .edge_en    (edge_en),
    .edge_color (edge_color),
    .win_hit    (win_hit),
    .win_color  (win_color),
    .wshd_hit   (wshd_hit),
    .wshd_color (wshd_color),
    .src        (sel_src),
    .color      (sel_color)
  );

  osd_out_stage u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .osd_en        (osd_en),
    .drive_low_sel (drive_low_sel),
    .blank_fg_only (blank_fg_only),
    .src           (sel_src),
    .color         (sel_color),
    .rgb           (rgb),
    .blank         (blank),
    .out_en        (out_en)
  );

endmodule

// File: rtl/osd_pixel_mixer_chk.sv
module osd_pixel_mixer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       osd_en,
  input logic       drive_low_sel,
  input logic       fg_bit,
  input logic       cell_blink,
  input logic [2:0] cell_fg,
  input logic [2:0] cell_bg,
  input logic       edge_dot,
  input logic       edge_en,
  input logic       win_hit,
  input logic       wshd_hit,
  input logic [2:0] rgb,
  input logic       blank,
  input logic       out_en,
  input logic       vs_edge,
  input logic       blink_on
);

  // R1: a non-blinking glyph dot always wins and blanks.
  assert_fg_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(osd_en && fg_bit && !cell_blink))
      |-> (blank && rgb == $past(cell_fg)));

  // R5: nothing to paint gives black and no blank.
  assert_empty_dot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(osd_en && !fg_bit && !(edge_dot && edge_en)
                           && cell_bg == 3'b000 && !win_hit && !wshd_hit))
      |-> (!blank && rgb == 3'b000));

  // R10: disabled display outputs zero.
  assert_off_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(osd_en)) |-> (rgb == 3'b000 && !blank));

  // R10: pad enable follows the drive selection.
  assert_out_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_en == ($past(osd_en) || $past(drive_low_sel))));

  // R7: the blink phase only moves on a counted VS edge.
  assert_blink_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vs_edge && !soft_rst) |=> $stable(blink_on));

  // R9: soft reset returns the phase to visible.
  assert_soft_rst_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> blink_on);

endmodule

bind osd_pixel_mixer osd_pixel_mixer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .soft_rst      (soft_rst),
  .osd_en        (osd_en),
  .drive_low_sel (drive_low_sel),
  .fg_bit        (fg_bit),
  .cell_blink    (cell_blink),
  .cell_fg       (cell_fg),
  .cell_bg       (cell_bg),
  .edge_dot      (edge_dot),
  .edge_en       (edge_en),
  .win_hit       (win_hit),
  .wshd_hit      (wshd_hit),
  .rgb           (rgb),
  .blank         (blank),
  .out_en        (out_en),
  .vs_edge       (vs_edge),
  .blink_on      (blink_on)
);

// File: tb/tb_osd_pixel_mixer.sv
module tb_osd_pixel_mixer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       osd_en = 1'b0;
  logic       drive_low_sel = 1'b0;
  logic       blank_fg_only = 1'b0;
  logic       vs_in = 1'b0;
  logic       vs_pos_pol = 1'b1;
  logic       fg_bit = 1'b0;
  logic       cell_blink = 1'b0;
  logic [2:0] cell_fg = 3'd0;
  logic [2:0] cell_bg = 3'd0;
  logic       edge_dot = 1'b0;
  logic       edge_en = 1'b0;
  logic [2:0] edge_color = 3'd0;
  logic       win_hit = 1'b0;
  logic [2:0] win_color = 3'd0;
  logic       wshd_hit = 1'b0;
  logic [2:0] wshd_color = 3'd0;
  logic [2:0] rgb;
  logic       blank;
  logic       out_en;

  osd_pixel_mixer dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .osd_en(osd_en),
    .drive_low_sel(drive_low_sel), .blank_fg_only(blank_fg_only),
    .vs_in(vs_in), .vs_pos_pol(vs_pos_pol), .fg_bit(fg_bit),
    .cell_blink(cell_blink), .cell_fg(cell_fg), .cell_bg(cell_bg),
    .edge_dot(edge_dot), .edge_en(edge_en), .edge_color(edge_color),
    .win_hit(win_hit), .win_color(win_color), .wshd_hit(wshd_hit),
    .wshd_color(wshd_color), .rgb(rgb), .blank(blank), .out_en(out_en)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic [4:0] exp;  // {out_en, blank, rgb}
    int         due;
    string      tag;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  int    vs_count = 0;  // bench's own count of active VS edges
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Reference model, stated from the requirements.
  function automatic logic [4:0] model();
    logic       hidden;
    logic [2:0] col;
    if (!osd_en) return {drive_low_sel, 1'b0, 3'b000};            // R10
    hidden = cell_blink && ((vs_count % 64) >= 32);               // R7
    if (fg_bit && !hidden) return {1'b1, 1'b1, cell_fg};          // R1
    if (edge_en && edge_dot) return {1'b1, 1'b1, edge_color};     // R2
    if (cell_bg != 3'b000)  col = cell_bg;                        // R3
    else if (wshd_hit)      col = wshd_color;                     // R4
    else if (win_hit)       col = win_color;
    else return 5'b10000;                                         // R5
    return {1'b1, ~blank_fg_only, col};                           // R6
  endfunction

  // Driver: inputs are set at a falling edge; result due after next rising edge.
  task automatic drive(input string tag);
    item_t it;
    it.exp = model();
    it.due = cyc + 1;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      n_vec++;
      if ({out_en, blank, rgb} !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got oe/blank/rgb=%b/%b/%b expected %b/%b/%b",
                 it.tag, out_en, blank, rgb, it.exp[4], it.exp[3], it.exp[2:0]);
      end
    end
  end

  task automatic vs_pulse();
    vs_in = vs_pos_pol;
    repeat (4) @(negedge clk);
    vs_in = ~vs_pos_pol;
    vs_count++;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_px();
    fg_bit = 0; cell_blink = 0; edge_dot = 0; edge_en = 0;
    cell_bg = 0; win_hit = 0; wshd_hit = 0;
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    n_vec++;
    if ({out_en, blank, rgb} !== 5'b0) begin
      n_bad++;
      $display("FAIL R11 reset: got %b expected 00000", {out_en, blank, rgb});
    end
    rst_n = 1;
    @(negedge clk);
    osd_en = 1;
    cell_fg = 3'b110; edge_color = 3'b011; win_color = 3'b001; wshd_color = 3'b101;

    // R1 glyph over everything, several colours, back to back (R11 latency)
    for (int c = 0; c < 8; c++) begin
      fg_bit = 1; cell_fg = 3'(c); edge_dot = 1; edge_en = 1;
      cell_bg = 3'b100; win_hit = 1; wshd_hit = c[0];
      drive("R1 glyph wins");
    end
    // R2 outline
    fg_bit = 0; cell_fg = 3'b010;
    drive("R2 outline over bg");
    edge_en = 0;
    drive("R2 outline disabled ignored");
    // R3 opaque background over window sources
    edge_dot = 0; cell_bg = 3'b111;
    drive("R3 opaque bg");
    // R4 transparent falls through
    cell_bg = 3'b000; wshd_hit = 1; win_hit = 1;
    drive("R4 shadow over window");
    wshd_hit = 0;
    drive("R4 window colour");
    // R5 nothing
    win_hit = 0;
    drive("R5 empty dot");

    // R6 blank policy repeated with fg-only
    blank_fg_only = 1;
    fg_bit = 1; drive("R6 fg blanks");
    fg_bit = 0; edge_dot = 1; edge_en = 1; drive("R6 outline blanks");
    edge_dot = 0; cell_bg = 3'b010; drive("R6 bg no blank");
    cell_bg = 0; wshd_hit = 1; drive("R6 shadow no blank");
    wshd_hit = 0; win_hit = 1; drive("R6 window no blank");
    win_hit = 0; drive("R6 empty");
    blank_fg_only = 0;

    // R7 blink boundaries
    clear_px(); fg_bit = 1; cell_blink = 1; cell_bg = 3'b001; cell_fg = 3'b111;
    drive("R7 count 0 visible");
    repeat (31) vs_pulse();
    drive("R7 count 31 visible");
    vs_pulse();
    drive("R7 count 32 hidden");
    cell_bg = 0; win_hit = 1;
    drive("R7 hidden shows window");
    cell_blink = 0;
    drive("R7 non-blink cell unaffected");
    cell_blink = 1; cell_bg = 3'b001; win_hit = 0;
    repeat (31) vs_pulse();
    drive("R7 count 63 hidden");
    vs_pulse();
    drive("R7 count 64 wraps visible");

    // R9 soft reset
    repeat (40) vs_pulse();
    drive("R9 count 40 hidden");
    soft_rst = 1; @(negedge clk); soft_rst = 0; vs_count = 0;
    drive("R9 after soft reset visible");

    // R8 negative polarity: falling edges count, rising do not
    vs_pos_pol = 0; vs_in = 1;
    repeat (6) @(negedge clk);
    drive("R8 idle rise not counted");
    repeat (32) vs_pulse();
    drive("R8 32 falling edges hidden");
    repeat (32) vs_pulse();
    drive("R8 64 falling edges visible");

    // R10 disabled display
    osd_en = 0; drive_low_sel = 1;
    drive("R10 off drive low");
    drive_low_sel = 0;
    drive("R10 off released");
    osd_en = 1;
    drive("R10 back on");
    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule